// File: doc/BRIEF.md
# Shared-Memory Mailbox Bank with Doorbells

This block holds a bank of hardware message channels. Requesting agents and a single platform controller use it to exchange power-management messages that follow a shared-memory mailbox protocol. Each channel is a forty-byte area of ten 32-bit words. Both sides read and write it through one word-wide memory-mapped slave port. Word 0 carries the requester's agent identifier, so several agents can take turns on one channel and one interrupt line. Word 1 is the channel status. Word 4 holds the flags and word 5 the length. Word 6 is the message header, words 7 and 8 the payload, and words 2, 3 and 9 are spare.

The agent fills a channel and clears the status "free" bit. It then rings that channel's doorbell. The doorbell raises one interrupt line per channel toward the platform's local interrupt controller, and the line stays raised until the platform clears it. When the platform finishes, it writes the status word with "free" set again. If the agent asked for a completion notice in the flags word, an interrupt back toward the agent is raised and held until it is acknowledged. The block does not interpret the contents of the messages.

Top module: `mbx_bank`

## Requirements
- R1: After reset both interrupt vectors are zero, every channel's status word (word 1) reads 1 (free), and every other message word reads 0.
- R2: Word w of channel c sits at byte address 40*c + 4*w for c in 0..63 and w in 0..9. A write stores all 32 bits. A read request in one cycle presents the stored word on rd_data after the next rising edge, and rd_data holds that value until the next read.
- R3: A write to one message word changes no other word, in the same channel or in any other channel.
- R4: Writing bit 0 = 1 to the ring register of channel c (byte 0x1000 + 16*c) sets that channel's pending bit, and doorbell_irq[c] is high after that edge. A write with bit 0 = 0 has no effect.
- R5: A pending bit stays set until bit 0 = 1 is written to the channel's clear register (byte 0x1004 + 16*c). doorbell_irq[c] is low after that edge. The clear register reads 0.
- R6: A read of the ring register returns the channel's pending bit in bit 0 and zeros elsewhere.
- R7: A write to word 1 with bit 0 = 1 sets done_irq[c] after that edge, but only when the stored status bit 0 was 0 and the stored flags word (word 4) has bit 0 = 1. In every other case done_irq is unchanged. Status bit 1 (error) is plain storage.
- R8: done_irq[c] stays high until bit 0 = 1 is written to the acknowledge register (byte 0x1008 + 16*c). A read of that register returns the done bit in bit 0.
- R9: An access outside the two windows is void: a read returns 0 and a write changes nothing. This covers bytes 0xA00..0xFFF, 0x1400 and above, control offset 0xC of any channel, and any address with bits [1:0] non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| doorbell_irq | output | 64 | Per-channel interrupt toward the platform |
| done_irq | output | 64 | Per-channel completion interrupt toward the agent |

## Verification
A corrupted message word shows up only when that word is read back. The bench therefore reads words at random throughout the run, and reads every channel's status word after reset. A wrong pending or done bit shows on the interrupt vectors on the very next cycle, so the bench compares both full vectors against its model after every access. A completion that is missed or spurious follows from the mix of the flags bit and the old status bit, and each such case is driven directly. Decoding that leaks out of the windows would change a later readback or an interrupt vector, so every void access is followed by those same comparisons.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_MSG,
        RGN_CTRL
    } region_e;

    typedef enum logic [1:0] {
        CR_RING  = 2'd0,
        CR_CLEAR = 2'd1,
        CR_ACK   = 2'd2,
        CR_VOID  = 2'd3
    } ctrl_reg_e;

    localparam int STATUS_WORD = 1;
    localparam int FLAGS_WORD  = 4;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int CH_WORDS = 10,
    parameter int AW       = 13,
    parameter int CH_W     = 6,
    parameter int IDX_W    = 4
) (
    input  logic [AW-1:0]    addr,
    output region_e          region,
    output logic [CH_W-1:0]  ch,
    output logic [IDX_W-1:0] idx,
    output ctrl_reg_e        creg
);
    localparam int WA_W = AW - 2;
    localparam int CW_W = AW - 3;
    localparam logic [WA_W-1:0] MSG_LIMIT  = WA_W'(NUM_CH * CH_WORDS);
    localparam logic [CW_W-1:0] CTRL_LIMIT = CW_W'(NUM_CH * 4);

    logic [WA_W-1:0] wa_s;
    logic [WA_W-1:0] quot_s;
    logic [WA_W-1:0] rem_s;

    always_comb begin
        wa_s   = addr[AW-1:2];
        quot_s = wa_s / WA_W'(CH_WORDS);
        rem_s  = wa_s % WA_W'(CH_WORDS);
        region = RGN_NONE;
        ch     = '0;
        idx    = '0;
        creg   = ctrl_reg_e'(addr[3:2]);
        if (addr[1:0] == 2'b00) begin
            if (wa_s < MSG_LIMIT) begin
                region = RGN_MSG;
                ch     = CH_W'(quot_s);
                idx    = IDX_W'(rem_s);
            end else if (addr[AW-1] && (addr[AW-2:2] < CTRL_LIMIT)
                         && (addr[3:2] != 2'd3)) begin
                region = RGN_CTRL;
                ch     = addr[CH_W+3:4];
            end
        end
    end
endmodule

// File: rtl/mbx_msg_store.sv
module mbx_msg_store
    import mbx_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int CH_WORDS = 10,
    parameter int DW       = 32,
    parameter int CH_W     = 6,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   ch,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_word,
    output logic [NUM_CH-1:0] free_vec,
    output logic [NUM_CH-1:0] flag_vec
);
    typedef struct packed {
        logic [NUM_CH-1:0][CH_WORDS-1:0][DW-1:0] words;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.words[ch][idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int w = 0; w < CH_WORDS; w++) begin
                    st_q.words[c][w] <= (w == STATUS_WORD) ? DW'(1) : '0;
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word = st_q.words[ch][idx];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bits
        assign free_vec[g] = st_q.words[g][STATUS_WORD][0];
        assign flag_vec[g] = st_q.words[g][FLAGS_WORD][0];
    end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
    parameter int NUM_CH = 64,
    parameter int CH_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   ch,
    input  logic              ring,
    input  logic              clear,
    input  logic              complete,
    input  logic              ack,
    output logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] done
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] done;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (ring)     fl_d.pend[ch] = 1'b1;
        if (clear)    fl_d.pend[ch] = 1'b0;
        if (complete) fl_d.done[ch] = 1'b1;
        if (ack)      fl_d.done[ch] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign pend = fl_q.pend;
    assign done = fl_q.done;

    // R4
    ring_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring |=> pend[$past(ch)]);

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (($past(pend) & ~pend) == '0));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & ~$past(done)) != '0) |-> $past(complete));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> (($past(done) & ~done) == '0));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int CH_WORDS = 10,
    parameter int DW       = 32,
    parameter int AW       = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic [DW-1:0]     rd_data,
    output logic [NUM_CH-1:0] doorbell_irq,
    output logic [NUM_CH-1:0] done_irq
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int IDX_W = $clog2(CH_WORDS);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } port_t;

    port_t pt_d, pt_q;

    region_e           region;
    ctrl_reg_e         creg;
    logic [CH_W-1:0]   ch;
    logic [IDX_W-1:0]  idx;
    logic [DW-1:0]     rd_word;
    logic [NUM_CH-1:0] free_vec;
    logic [NUM_CH-1:0] flag_vec;
    logic              wr_s, msg_we, ctrl_we;
    logic              ring_s, clear_s, complete_s, ack_s;

    mbx_decode #(
        .NUM_CH(NUM_CH), .CH_WORDS(CH_WORDS), .AW(AW), .CH_W(CH_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr(req_addr), .region(region), .ch(ch), .idx(idx), .creg(creg)
    );

    mbx_msg_store #(
        .NUM_CH(NUM_CH), .CH_WORDS(CH_WORDS), .DW(DW), .CH_W(CH_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(msg_we), .ch(ch), .idx(idx),
        .wdata(req_wdata), .rd_word(rd_word),
        .free_vec(free_vec), .flag_vec(flag_vec)
    );

    always_comb begin
        wr_s       = req_valid && req_write;
        msg_we     = wr_s && (region == RGN_MSG);
        ctrl_we    = wr_s && (region == RGN_CTRL) && req_wdata[0];
        ring_s     = ctrl_we && (creg == CR_RING);
        clear_s    = ctrl_we && (creg == CR_CLEAR);
        ack_s      = ctrl_we && (creg == CR_ACK);
        complete_s = msg_we && (idx == IDX_W'(STATUS_WORD)) && req_wdata[0]
                     && !free_vec[ch] && flag_vec[ch];
    end

    mbx_flags #(
        .NUM_CH(NUM_CH), .CH_W(CH_W)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .ch(ch), .ring(ring_s), .clear(clear_s),
        .complete(complete_s), .ack(ack_s), .pend(doorbell_irq), .done(done_irq)
    );

    always_comb begin
        pt_d = pt_q;
        if (req_valid && !req_write) begin
            case (region)
                RGN_MSG:  pt_d.rdata = rd_word;
                RGN_CTRL: begin
                    case (creg)
                        CR_RING: pt_d.rdata = DW'(doorbell_irq[ch]);
                        CR_ACK:  pt_d.rdata = DW'(done_irq[ch]);
                        default: pt_d.rdata = '0;
                    endcase
                end
                default:  pt_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign rd_data = pt_q.rdata;

    // R9
    void_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && region == RGN_NONE) |=> (rd_data == '0));

    // R9
    void_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && region == RGN_NONE)
        |=> ($stable(doorbell_irq) && $stable(done_irq)));

    // R4
    one_ring_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(doorbell_irq & ~$past(doorbell_irq)) <= 1);
endmodule

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;
    localparam int NCH = 64;
    localparam int NW  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [63:0] doorbell_irq;
    logic [63:0] done_irq;

    always #2.5 clk = ~clk;

    mbx_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .doorbell_irq(doorbell_irq), .done_irq(done_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    logic [31:0] mem_m [NCH][NW];
    logic [63:0] pend_m;
    logic [63:0] done_m;

    function automatic int msg_addr(int c, int w);
        return 40 * c + 4 * w;
    endfunction

    function automatic int ctl_addr(int c, int r);
        return 32'h1000 + 16 * c + 4 * r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int a);
        int c, w, r;
        if (a[1:0] != 2'b00) return '0;
        if (a < 2560) begin
            c = (a >> 2) / 10;
            w = (a >> 2) % 10;
            return mem_m[c][w];
        end
        if (a >= 32'h1000 && a < 32'h1400) begin
            c = (a - 32'h1000) >> 4;
            r = (a >> 2) & 3;
            if (r == 0) return {31'b0, pend_m[c]};
            if (r == 2) return {31'b0, done_m[c]};
        end
        return '0;
    endfunction

    task automatic model_write(int a, logic [31:0] d);
        int c, w, r;
        if (a[1:0] != 2'b00) return;
        if (a < 2560) begin
            c = (a >> 2) / 10;
            w = (a >> 2) % 10;
            if (w == 1 && d[0] && !mem_m[c][1][0] && mem_m[c][4][0]) done_m[c] = 1'b1;
            mem_m[c][w] = d;
        end else if (a >= 32'h1000 && a < 32'h1400 && d[0]) begin
            c = (a - 32'h1000) >> 4;
            r = (a >> 2) & 3;
            if (r == 0) pend_m[c] = 1'b1;
            if (r == 1) pend_m[c] = 1'b0;
            if (r == 2) done_m[c] = 1'b0;
        end
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 13'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(int a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 13'(a);
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic read_check(string req, int a);
        logic [31:0] v;
        bus_read(a, v);
        check(req, 64'(v), 64'(model_read(a)));
    endtask

    task automatic irq_check(string req);
        check({req, " doorbell"}, doorbell_irq, pend_m);
        check({req, " done"}, done_irq, done_m);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < NW; w++)
                mem_m[c][w] = (w == 1) ? 32'd1 : 32'd0;
        pend_m = '0;
        done_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        irq_check("R1");
        check("R1 rdata", 64'(rd_data), 64'd0);
        read_check("R1 status ch0", msg_addr(0, 1));
        read_check("R1 status ch63", msg_addr(63, 1));
        read_check("R1 word0 ch63", msg_addr(63, 0));
        read_check("R1 payload ch17", msg_addr(17, 8));

        // R2 word placement, one-cycle read latency
        bus_write(msg_addr(5, 7), 32'hCAFE_0507);
        bus_read(msg_addr(5, 7), v);
        check("R2 readback", 64'(v), 64'h0000_0000_CAFE_0507);
        // R3 neighbours untouched
        read_check("R3 neighbour word", msg_addr(5, 8));
        read_check("R3 next channel", msg_addr(6, 7));

        // R4/R6 ring with bit0=0 ignored, then with bit0=1
        bus_write(ctl_addr(9, 0), 32'hFFFF_FFFE);
        check("R4 bit0 zero", 64'(doorbell_irq[9]), 64'd0);
        bus_write(ctl_addr(9, 0), 32'd1);
        check("R4 ring", 64'(doorbell_irq[9]), 64'd1);
        read_check("R6 ring read", ctl_addr(9, 0));
        // R5 sticky, clear reads 0, then clear
        bus_write(ctl_addr(9, 2), 32'd1);
        check("R5 sticky", 64'(doorbell_irq[9]), 64'd1);
        read_check("R5 clear reads zero", ctl_addr(9, 1));
        bus_write(ctl_addr(9, 1), 32'd1);
        check("R5 cleared", 64'(doorbell_irq[9]), 64'd0);

        // R7 no completion when flags bit0 = 0
        bus_write(msg_addr(3, 1), 32'd0);
        bus_write(msg_addr(3, 1), 32'd1);
        check("R7 no flag", 64'(done_irq[3]), 64'd0);
        // R7 no completion when already free
        bus_write(msg_addr(4, 4), 32'd1);
        bus_write(msg_addr(4, 1), 32'd3);
        check("R7 already free", 64'(done_irq[4]), 64'd0);
        // R7 completion
        bus_write(msg_addr(4, 1), 32'd2);
        bus_write(msg_addr(4, 1), 32'd1);
        check("R7 completion", 64'(done_irq[4]), 64'd1);
        // R8 read, sticky, ack
        read_check("R8 done read", ctl_addr(4, 2));
        bus_write(ctl_addr(4, 0), 32'd1);
        check("R8 sticky", 64'(done_irq[4]), 64'd1);
        bus_write(ctl_addr(4, 2), 32'd1);
        check("R8 acked", 64'(done_irq[4]), 64'd0);

        // R9 void windows and misaligned
        bus_write(32'hA00, 32'hFFFF_FFFF);
        bus_write(32'h1400, 32'd1);
        bus_write(ctl_addr(7, 3), 32'd1);
        bus_write(msg_addr(2, 3) + 1, 32'hDEAD_BEEF);
        irq_check("R9 void writes");
        read_check("R9 misaligned target", msg_addr(2, 3));
        bus_read(msg_addr(2, 3) + 2, v);
        check("R9 misaligned read", 64'(v), 64'd0);
        bus_read(32'hFFC, v);
        check("R9 gap read", 64'(v), 64'd0);
        bus_read(ctl_addr(7, 3), v);
        check("R9 void ctrl read", 64'(v), 64'd0);

        // random mix against the model
        for (int i = 0; i < 3000; i++) begin
            int c, op, a;
            logic [31:0] d;
            c  = int'($urandom % NCH);
            op = int'($urandom % 10);
            d  = $urandom;
            case (op)
                0, 1: begin
                    a = msg_addr(c, int'($urandom % NW));
                    bus_write(a, d);
                    irq_check("R3 random write");
                end
                2: begin
                    bus_write(msg_addr(c, 4), {31'd0, d[0]});
                    bus_write(msg_addr(c, 1), {30'd0, d[2:1]});
                    irq_check("R7 random status");
                end
                3, 4: read_check("R2 random read", msg_addr(c, int'($urandom % NW)));
                5: begin
                    bus_write(ctl_addr(c, 0), d);
                    irq_check("R4 random ring");
                end
                6: begin
                    bus_write(ctl_addr(c, 1), d);
                    irq_check("R5 random clear");
                end
                7: begin
                    bus_write(ctl_addr(c, 2), d);
                    irq_check("R8 random ack");
                end
                8: read_check("R6 random ctrl read", ctl_addr(c, int'($urandom % 4)));
                default: begin
                    if (d[0]) a = 32'hA00 + int'($urandom % 32'h600);
                    else      a = 32'h1400 + int'($urandom % 32'hC00);
                    a = a & ~3;
                    if (d[1]) begin
                        bus_write(a, $urandom);
                        irq_check("R9 random void write");
                    end else begin
                        read_check("R9 random void read", a);
                    end
                end
            endcase
        end

        for (int c = 0; c < NCH; c++) read_check("R3 final status", msg_addr(c, 1));
        finish_run();
    end
endmodule